// File: doc/BRIEF.md
# Configurable 1:8 Serial Deserializer

This block turns a serial bit stream into parallel words of eight bits. Each word comes with a one-cycle valid strobe and a word clock that rises once per word. One of two serial inputs feeds the block, chosen by a select line. A mode pin picks the sampling scheme. With single-edge capture, one bit is taken at each rising clock edge. With dual-edge capture, a bit is taken at each rising edge and another at each falling edge, and the pair enters the word together at the next rising edge.

To realign the word boundary, the block drops exactly one serial bit for each request on an asynchronous alignment pin. A synchronous run enable freezes the word path cleanly. An asynchronous reset clears all state.

The word output is a stream with a valid strobe and no ready. Serial data cannot be held back, so the block does not accept back-pressure. A consumer must take each word in the cycle its strobe is high. The word itself stays on the output until the next word replaces it.

Top module: `deser_1to8`

## Requirements
- R1: An active-high `rst_i` clears the block at once, without waiting for a clock edge. After reset, `word_o` is 0, `word_valid_o` is 0 and `word_clk_o` is 0. The first word appears after 8 accepted bits.
- R2: With `single_edge_i` high, a bit is sampled only at rising edges. A bit sampled at rising edge e is shifted into the word at edge e+1. The first bit of a word lands on `word_o[7]` and the last on `word_o[0]`.
- R3: With `single_edge_i` low, a bit is sampled at each rising edge and at the falling edge that follows it. The pair is shifted in at the next rising edge, and the bit sampled on the rising edge counts as the earlier of the two.
- R4: With `sel_b_i` low, `ser_a_i` is the data source and `ser_b_i` has no effect. With `sel_b_i` high, `ser_b_i` is the source and `ser_a_i` has no effect.
- R5: `word_o` is loaded in the same cycle that the eighth bit of a word is shifted in. `word_valid_o` is high for exactly that one cycle. Without pauses or slips, words arrive every 8 cycles in single-edge mode and every 4 cycles in dual-edge mode.
- R6: `word_clk_o` rises in the same cycle as each `word_valid_o`. It stays high for the first half of the word period: 4 cycles in single-edge mode, 2 in dual-edge mode. It then falls.
- R7: A sampled bit enters the word only if `run_i` is high at the rising edge that would shift it in. Bits that do not enter are discarded. While `run_i` is low at an edge, `word_o` and `word_clk_o` hold their values and `word_valid_o` stays low.
- R8: A rising edge on `align_i` passes through a two-stage synchronizer. It then drops exactly one bit: the bit sampled at the rising edge two cycles after the first edge that saw `align_i` high. In dual-edge mode this is the rising-edge bit of that pair. `align_i` should stay high for at least three cycles.
- R9: Each low-to-high change of `align_i` causes exactly one slip, however long the pin stays high. A further slip needs `align_i` to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| single_edge_i | input | 1 | 1: rising-edge capture, 0: dual-edge capture |
| sel_b_i | input | 1 | 0: take `ser_a_i`, 1: take `ser_b_i` |
| ser_a_i | input | 1 | Serial data input A |
| ser_b_i | input | 1 | Serial data input B |
| run_i | input | 1 | Synchronous run enable, active high |
| align_i | input | 1 | Asynchronous bit-slip request |
| word_o | output | 8 | Parallel word, first serial bit in bit 7 |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| word_clk_o | output | 1 | Parallel word clock |

## Verification
The bench drives the inputs 1 ns after each falling edge. In dual-edge mode it also drives the second bit of each pair 1 ns after the rising edge. It samples the outputs 2 ns after each rising edge.

A bit sampled at rising edge e shows up in the word loaded at e+1. That load is seen by the sample in that same cycle, together with the valid strobe and the word clock rising.

The bench's model follows the same cycle rules. A bit enters its expected words only if the run level driven for the next edge is high. For a request first seen at edge c, the model leaves out the bit sampled at edge c+2. Completed expected words go into a queue, and a monitor compares each one with the output when the strobe appears.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Bits a single rising edge can move into the word: rising + falling sample.
  localparam int unsigned LANES = 2;

  typedef struct packed {
    logic fall;   // bit sampled on the falling edge (later bit of a pair)
    logic rise;   // bit sampled on the rising edge (earlier bit of a pair)
    logic vld;    // at least one rising edge seen since reset
  } cap_t;

endpackage

// File: rtl/deser_capture.sv
module deser_capture
  import deser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic dual_i,
  input  logic sel_b_i,
  input  logic ser_a_i,
  input  logic ser_b_i,
  output cap_t cap_o
);

  logic bit_sel;
  logic rise_q;
  logic fall_q;
  logic vld_q;

  assign bit_sel = sel_b_i ? ser_b_i : ser_a_i;

  // Rising-edge sampler; vld marks that rise_q holds a real sample.
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      rise_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      rise_q <= bit_sel;
      vld_q  <= 1'b1;
    end
  end

  // Falling-edge sampler, only clocked in when dual-edge mode is chosen.
  always_ff @(negedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      fall_q <= 1'b0;
    end else if (dual_i) begin
      fall_q <= bit_sel;
    end
  end

  assign cap_o = '{fall: fall_q, rise: rise_q, vld: vld_q};

endmodule

// File: rtl/deser_align.sv
module deser_align #(
  parameter int unsigned SYNC_STAGES = 2   // must be 2 or more
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic align_i,
  input  logic take_i,
  output logic pend_o
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   pend_q;
  logic                   rise_seen;

  assign rise_seen = sync_q[TOP] & ~last_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      sync_q <= '0;
      last_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], align_i};
      last_q <= sync_q[TOP];
      pend_q <= rise_seen | (pend_q & ~take_i);
    end
  end

  assign pend_o = pend_q;

  // A consumed request is gone the next cycle: one slip per request.
  AST_SLIP_CONSUMED: assert property (@(posedge clk_i) disable iff (rst_i)
    take_i |=> !pend_q);  // R9

endmodule

// File: rtl/deser_assemble.sv
module deser_assemble
  import deser_pkg::*;
#(
  parameter int unsigned WORD_W = 8   // power of two, 4 or more
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic              dual_i,
  input  cap_t              cap_i,
  input  logic              slip_i,
  output logic              slip_take_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              word_clk_o
);

  localparam int unsigned        CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0]   LAST  = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              vld_q, clk_q, clk_n, load;
  logic              step;
  logic [LANES-1:0]  lane_use;
  logic [LANES-1:0]  lane_bit;

  assign step        = run_i & cap_i.vld;
  assign slip_take_o = step & slip_i;
  assign lane_bit    = {cap_i.fall, cap_i.rise};
  assign lane_use[0] = step & ~slip_i;   // a slip drops the earlier bit
  assign lane_use[1] = step & dual_i;

  // Walk the lanes in serial order; a word may complete on either lane.
  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    word_n = word_q;
    load   = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_use[l]) begin
        if (cnt_n == LAST) begin
          word_n = {sh_n[WORD_W-2:0], lane_bit[l]};
          load   = 1'b1;
        end
        sh_n  = {sh_n[WORD_W-2:0], lane_bit[l]};
        cnt_n = cnt_n + CNT_W'(1);
      end
    end
    // Word clock: set on a new word, cleared once the count passes half.
    if (load)                clk_n = 1'b1;
    else if (cnt_n[CNT_W-1]) clk_n = 1'b0;
    else                     clk_n = clk_q;
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      word_q <= word_n;
      vld_q  <= load;
      clk_q  <= clk_n;
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = vld_q;
  assign word_clk_o   = clk_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    word_valid_o |=> !word_valid_o);  // R5

  AST_WCLK_RISES_WITH_WORD: assert property (@(posedge clk_i) disable iff (rst_i)
    word_valid_o |-> $rose(word_clk_o));  // R6

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> ($stable(word_o) && $stable(word_clk_o) && !word_valid_o));  // R7

  AST_VALID_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
    word_valid_o |-> $past(run_i));  // R7

endmodule

// File: rtl/deser_1to8.sv
module deser_1to8
  import deser_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              single_edge_i,
  input  logic              sel_b_i,
  input  logic              ser_a_i,
  input  logic              ser_b_i,
  input  logic              run_i,
  input  logic              align_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              word_clk_o
);

  cap_t cap;
  logic dual;
  logic slip_pend;
  logic slip_take;

  assign dual = ~single_edge_i;

  deser_capture u_capture (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .dual_i  (dual),
    .sel_b_i (sel_b_i),
    .ser_a_i (ser_a_i),
    .ser_b_i (ser_b_i),
    .cap_o   (cap)
  );

  deser_align #(.SYNC_STAGES(SYNC_STAGES)) u_align (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .align_i (align_i),
    .take_i  (slip_take),
    .pend_o  (slip_pend)
  );

  deser_assemble #(.WORD_W(WORD_W)) u_assemble (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .run_i        (run_i),
    .dual_i       (dual),
    .cap_i        (cap),
    .slip_i       (slip_pend),
    .slip_take_o  (slip_take),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .word_clk_o   (word_clk_o)
  );

endmodule

// File: tb/test_deser_1to8.sv
module test_deser_1to8;

  logic clk = 1'b0;
  always #5 clk = ~clk;   // 100 MHz

  logic       rst_i = 1'b1, single_edge_i = 1'b1, sel_b_i = 1'b0;
  logic       ser_a_i = 1'b0, ser_b_i = 1'b0, run_i = 1'b0, align_i = 1'b0;
  logic [7:0] word_o;
  logic       word_valid_o, word_clk_o;

  deser_1to8 i_deser_1to8 (
    .clk_i(clk), .rst_i(rst_i), .single_edge_i(single_edge_i), .sel_b_i(sel_b_i),
    .ser_a_i(ser_a_i), .ser_b_i(ser_b_i), .run_i(run_i), .align_i(align_i),
    .word_o(word_o), .word_valid_o(word_valid_o), .word_clk_o(word_clk_o)
  );

  int         n_tests = 0, n_fail = 0;
  bit         done = 0;
  string      tag = "R2";
  logic [7:0] exp_q[$];

  // Reference model state
  int         cyc, drop_idx, acc_n;
  logic       pr, pf, al_prev;
  bit         have_prev;
  logic [7:0] acc;
  logic [15:0] lfsr = 16'hACE1;

  // Monitor state
  int   gap_cnt = 0, hi_cnt = 0, last_gap = 0, last_hi = 0;
  logic prev_clk = 1'b0;
  logic [7:0] prev_word = '0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  function automatic void take_bit(logic b);
    acc = {acc[6:0], b};
    acc_n++;
    if (acc_n == 8) begin
      exp_q.push_back(acc);
      acc_n = 0;
    end
  endfunction

  task automatic put_bit(logic b);
    if (sel_b_i) begin ser_b_i = b; ser_a_i = ~b; end   // R4: other input toggles
    else         begin ser_a_i = b; ser_b_i = ~b; end
  endtask

  // One bit period: r is sampled at the coming rising edge, f at the falling
  // edge after it (dual mode only). Model: the pair from the previous call is
  // accepted if run is high now; a request first seen at call c drops call c+2.
  task automatic drive(logic r, logic f, logic run, logic al);
    @(negedge clk); #1;
    rst_i = 1'b0;
    put_bit(r);
    run_i = run;
    align_i = al;
    if (al && !al_prev) drop_idx = cyc + 2;
    al_prev = al;
    if (run && have_prev) begin
      if (drop_idx != cyc - 1) take_bit(pr);
      if (!single_edge_i) take_bit(pf);
    end
    have_prev = 1;
    pr = r;
    pf = f;
    cyc++;
    if (!single_edge_i) begin
      @(posedge clk); #1;
      put_bit(f);
    end
  endtask

  task automatic do_reset(logic single, logic selb);
    @(negedge clk); #1;
    rst_i = 1'b1;
    run_i = 1'b0;
    align_i = 1'b0;
    single_edge_i = single;
    sel_b_i = selb;
    have_prev = 0; acc_n = 0; cyc = 0; drop_idx = -10; al_prev = 1'b0;
    @(posedge clk); #2;
    check("R1", "word after reset", word_o, 8'h00);
    check("R1", "valid after reset", word_valid_o, 1'b0);
    check("R1", "word clock after reset", word_clk_o, 1'b0);
  endtask

  // Drive n calls; run low every run_mod-th call (0: always high);
  // align high in two optional windows.
  task automatic stream(int n, int run_mod, int a1, int l1, int a2, int l2);
    for (int i = 0; i < n; i++) begin
      logic r, f, run, al;
      r = next_bit();
      f = next_bit();
      run = (run_mod == 0) ? 1'b1 : ((i % run_mod) != (run_mod - 1));
      al = ((i >= a1) && (i < a1 + l1)) || ((i >= a2) && (i < a2 + l2));
      drive(r, f, run, al);
    end
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #3;
    check(tag, "all expected words delivered", exp_q.size(), 0);
  endtask

  task automatic check_rate(string rq, int per);
    check(rq, "word spacing", last_gap, per);
    check(rq, "word clock high cycles", last_hi, per / 2);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #2;
      if (!rst_i && !done) begin
        gap_cnt++;
        if (word_clk_o) hi_cnt++;
        if (!run_i) begin
          check("R7", "valid while stopped", word_valid_o, 1'b0);
          check("R7", "word held while stopped", word_o, prev_word);
          check("R7", "word clock held while stopped", word_clk_o, prev_clk);
        end
        if (word_valid_o) begin
          check("R6", "word clock rises with word", {prev_clk, word_clk_o}, 2'b01);
          if (exp_q.size() == 0) begin
            check(tag, "unexpected word", 1, 0);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(tag, "word value", word_o, e);
          end
          last_gap = gap_cnt;
          last_hi = hi_cnt;
          gap_cnt = 0;
          hi_cnt = 0;
        end
      end
      prev_clk = word_clk_o;
      prev_word = word_o;
    end
  end

  initial begin
    #3_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 + R2: single-edge, input A
    do_reset(1'b1, 1'b0);
    tag = "R2";
    stream(48, 0, -1, 0, -1, 0);
    check_rate("R5", 8);
    check_rate("R6", 8);

    // R4: input B selected, A carries the complement
    do_reset(1'b1, 1'b1);
    tag = "R4";
    stream(40, 0, -1, 0, -1, 0);

    // R7: run pauses discard bits and freeze the outputs
    do_reset(1'b1, 1'b0);
    tag = "R7";
    stream(60, 3, -1, 0, -1, 0);

    // R8: single-edge slip, align held three cycles
    do_reset(1'b1, 1'b0);
    tag = "R8";
    stream(56, 0, 10, 3, -1, 0);
    check_rate("R5", 8);

    // R9: align held long gives one slip; a second pulse gives one more
    do_reset(1'b1, 1'b1);
    tag = "R9";
    stream(72, 0, 5, 20, 40, 4);

    // R3: dual-edge capture
    do_reset(1'b0, 1'b0);
    tag = "R3";
    stream(32, 0, -1, 0, -1, 0);
    check_rate("R3", 4);
    check_rate("R6", 4);

    // R8 in dual-edge mode: odd word boundary afterwards
    do_reset(1'b0, 1'b1);
    tag = "R8";
    stream(36, 0, 6, 3, -1, 0);
    check_rate("R5", 4);

    // R7 in dual-edge mode
    do_reset(1'b0, 1'b0);
    tag = "R7";
    stream(40, 4, -1, 0, -1, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule